// File: doc/BRIEF.md
# IQ Sample MSB Packer

This block sits on a complex baseband stream. Each sample is 32 bits wide, with a 16-bit in-phase part in the upper half and a 16-bit quadrature part in the lower half, and it comes with a one-cycle valid strobe. For every accepted sample the block keeps only the top four bits of each component and forms one byte from them. Each byte is shifted into a 32-bit word, so the word always holds the four most recent bytes.

A modulo-four count of accepted samples sets the pace of the output. The output strobe is high while that count is three. While the strobe is high the packed word is on the output; at all other times the output reads zero. The result is one 32-bit word for every four samples, at a quarter of the sample rate. The only reduction is truncation: there is no rounding and no saturation. A synchronous reset and a packet-start clear both bring the block back to the start of a group.

Top module: `iq_msb_packer`

## Requirements
- R1: While `rst` is high at a rising edge, the accepted-sample count and the packed word go to zero. After that edge `out_vld` is 0 and `out_word` is 0.
- R2: The byte formed from a sample is {in_smp[31:28], in_smp[15:12]}: the I nibble sits in bits 7:4 of the byte and the Q nibble in bits 3:0.
- R3: On each accepted sample the packed word moves down by 8 bits and the new byte enters at bits 31:24. The oldest of the four bytes is in bits 7:0.
- R4: `out_vld` is 1 exactly when the number of samples accepted since the last reset or clear, taken modulo 4, equals 3. It stays 1 across idle cycles until the next accepted sample.
- R5: `out_word` is 0 whenever `out_vld` is 0.
- R6: The byte for a sample is taken from `in_smp` in the same cycle that `in_vld` is high. At the next edge that byte is already at bits 31:24.
- R7: A cycle with `in_vld` low and no reset or clear changes neither the count nor the packed word.
- R8: `clr` has the same effect as `rst`. When `clr` and `in_vld` are high in the same cycle, the clear wins and the sample is dropped.
- R9: After a reset or clear, byte positions not yet filled by an accepted sample read as zero when the word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous active-high packet-start clear |
| in_vld | input | 1 | Input sample valid strobe |
| in_smp | input | 32 | Complex sample: I in 31:16, Q in 15:0 |
| out_vld | output | 1 | Packed word valid |
| out_word | output | 32 | Packed word, or zero when not valid |

## Verification
Two events can fall in the same cycle: a sample acceptance and a clear. The clear must win. The bench provokes this by raising `clr` together with `in_vld`, both with the strobe low and with the strobe high. It judges the result by checking that the dropped sample never shows up in a later word and that the strobe timing starts again from zero. The bench also accepts a sample in a cycle where the strobe is high, and checks that the strobe drops and the word turns to zero in the next cycle.

// File: rtl/iq_msb_packer.sv
module iq_msb_packer #(
  parameter int COMP_W = 16,
  parameter int KEEP_W = 4,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          in_vld,
  input  logic [2*COMP_W-1:0]           in_smp,
  output logic                          out_vld,
  output logic [LANES*2*KEEP_W-1:0]     out_word
);
  localparam int BYTE_W = 2 * KEEP_W;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int SMP_W  = 2 * COMP_W;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [BYTE_W-1:0] nib;

  assign nib = {in_smp[SMP_W-1 -: KEEP_W], in_smp[COMP_W-1 -: KEEP_W]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      acc <= '0;
    end else if (in_vld) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      acc <= {nib, acc[WORD_W-1:BYTE_W]};
    end
  end

  assign out_vld  = (cnt == LAST);
  assign out_word = out_vld ? acc : '0;

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_vld && out_word == '0));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !clr) |=> ($stable(out_vld) && $stable(out_word)));

  assert_rise_needs_sample_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_vld) |-> $past(in_vld));

  assert_drop_after_word_R4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && in_vld && !clr) |=> !out_vld);

  assert_new_byte_top_R6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !clr) |=> acc[WORD_W-1 -: BYTE_W] ==
      {$past(in_smp[SMP_W-1 -: KEEP_W]), $past(in_smp[COMP_W-1 -: KEEP_W])});

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !clr) |=> acc[WORD_W-BYTE_W-1:0] == $past(acc[WORD_W-1:BYTE_W]));
endmodule

// File: tb/iq_msb_packer_test.sv
`timescale 1ns/1ps
module iq_msb_packer_test;
  logic clk = 1'b0;
  logic rst, clr, in_vld;
  logic [31:0] in_smp;
  logic out_vld;
  logic [31:0] out_word;

  int tests = 0, fails = 0;
  bit finished = 0;

  byte unsigned hist[$];
  int acc_n = 0;

  always #4 clk = ~clk;

  iq_msb_packer uut (
    .clk(clk), .rst(rst), .clr(clr), .in_vld(in_vld), .in_smp(in_smp),
    .out_vld(out_vld), .out_word(out_word)
  );

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (k < hist.size()) w[31-8*k -: 8] = hist[hist.size()-1-k];
    return w;
  endfunction

  task automatic compare(string tag);
    logic ev = ((acc_n % 4) == 3);
    logic [31:0] ew = ev ? model_word() : 32'h0;
    tests++;
    if (out_vld !== ev) begin
      fails++;
      $display("FAIL R4 (%s): out_vld=%0b expected %0b", tag, out_vld, ev);
    end
    tests++;
    if (out_word !== ew) begin
      fails++;
      $display("FAIL R5 (%s): out_word=%h expected %h", tag, out_word, ew);
    end
  endtask

  task automatic step(string tag, logic r, logic c, logic v, logic [31:0] s);
    @(negedge clk);
    compare(tag);
    rst = r; clr = c; in_vld = v; in_smp = s;
    @(posedge clk);
    if (r || c) begin
      hist.delete();
      acc_n = 0;
    end else if (v) begin
      hist.push_back({s[31:28], s[15:12]});
      if (hist.size() > 4) void'(hist.pop_front());
      acc_n++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; in_vld = 1'b0; in_smp = '0;
    step("R1 reset", 1, 0, 0, 32'hFFFF_FFFF);
    step("R1 reset", 1, 0, 1, 32'hABCD_1234);
    step("R1 idle", 0, 0, 0, 32'h0);
    // R2: nibble selection with distinct patterns
    step("R2", 0, 0, 1, 32'hA000_5000);
    step("R2", 0, 0, 1, 32'h0FFF_0FFF);
    // R9: missing low byte reads zero at the first word
    step("R9", 0, 0, 1, 32'h3123_C456);
    step("R9", 0, 0, 0, 32'h0);
    // R4: strobe persists through idle, then drops on next sample
    step("R4 idle", 0, 0, 0, 32'hFFFF_FFFF);
    step("R4", 0, 0, 1, 32'h7000_8000);
    // R3/R6: continuous stream
    for (int i = 0; i < 12; i++)
      step("R3", 0, 0, 1, 32'h1357_9BDF * (i + 1));
    // R7: gaps between samples
    for (int i = 0; i < 10; i++)
      step("R7", 0, 0, (i % 3) == 0, 32'hDEAD_BEEF ^ (i << 12));
    step("R6", 0, 0, 1, 32'h9000_6000);
    // R8: clear with a valid sample in the same cycle
    step("R8", 0, 1, 1, 32'hEEEE_EEEE);
    for (int i = 0; i < 3; i++)
      step("R8", 0, 0, 1, 32'h4000_2000 + (i << 28));
    step("R8 strobe", 0, 0, 0, 32'h0);
    step("R8", 0, 1, 1, 32'hBBBB_BBBB);
    step("R8", 0, 0, 0, 32'h0);
    // R1: reset mid group
    step("R1", 0, 0, 1, 32'h1111_1111);
    step("R1", 1, 0, 1, 32'h2222_2222);
    for (int i = 0; i < 5; i++)
      step("R5", 0, 0, 1, 32'hF0F0_0F0F + i * 32'h1010_1010);
    step("R5", 0, 0, 0, 32'h0);
    step("R5", 0, 0, 0, 32'h0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule